// File: doc/BRIEF.md
# Control-IN Endpoint Transmit Buffer

This block holds one outgoing data packet for the IN direction of a USB control endpoint. It sits between a CPU register interface and a USB packet engine. Firmware fills the buffer with 32-bit word writes. Each write carries byte enables, and the enabled bytes are appended in lane order, lowest lane first. Writing the data does not make it visible to the engine. The packet is armed only by a separate write of its byte count, and that count may be anything from zero to the buffer size.

While a packet is armed and no SETUP is pending, the block tells the packet engine that it is ready. The engine then pops bytes in the order they were written. When the host acknowledges the packet, the engine reports the ACK. The buffer empties and a transmit-done flag is raised. When the host does not acknowledge (timeout or NAK), the engine asks for a retry. The read position rewinds and the same packet is offered again. When nothing is armed, the engine sees "not ready" and answers IN tokens with NAK.

Firmware can discard the buffer and any armed packet with a clear strobe. A received SETUP does the same thing and also raises a setup-pending flag. While that flag is set, the block offers nothing to the engine, even if a new packet has been armed. Both flags are cleared by writing 1 to them. A set event in the same cycle as a clear write takes precedence.

Top module: `ctl_in_txbuf`

## Requirements
- R1: After reset, `eng_ready`, `tx_done` and `setup_pend` are 0.
- R2: Written bytes are not offered until the count is armed. After `cpu_arm_we` with count N, `eng_ready` is 1 and `eng_len` is N from the next cycle. `eng_byte` presents the written bytes in order: within a word, lane 0 (bits 7:0) comes first and lanes with a 0 byte enable are skipped. Each `eng_rd` advances to the next byte.
- R3: An arm count above 64 is ignored and the buffer stays unarmed. A count of 0 arms a zero-length packet.
- R4: Data writes and arm writes made while a packet is armed are ignored. The armed length and the contents do not change.
- R5: `eng_ack` while `eng_ready` disarms the packet, empties the buffer so the next packet starts from its first byte, and sets `tx_done` in the next cycle.
- R6: `eng_retry` while `eng_ready` rewinds to the first byte of the packet. The packet stays armed with the same length, and `tx_done` is not set.
- R7: A `cpu_clr_fifo` pulse discards the contents and any armed packet, so `eng_ready` is 0 in the next cycle. A data write in the same cycle as a clear or a SETUP is dropped.
- R8: `setup_rx` empties the buffer, disarms it, and sets `setup_pend`. While `setup_pend` is 1, `eng_ready` is 0 even if a packet is armed again.
- R9: `tx_done` is flag bit 0 and `setup_pend` is flag bit 1 of `cpu_flag_bits`. Writing 1 with `cpu_flag_we` clears a flag, and writing 0 leaves it unchanged. A set event in the same cycle as the clear write wins.
- R10: Bytes written beyond the 64th are dropped. A full 64-byte packet reads back the first 64 bytes written.
- R11: `eng_rd` and `eng_ack` while `eng_ready` is 0 have no effect. No byte is consumed and `tx_done` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_we | input | 1 | Data word write strobe |
| cpu_wr_data | input | 32 | Data word, lane 0 in bits 7:0 |
| cpu_wr_be | input | 4 | Byte enables for the data word |
| cpu_arm_we | input | 1 | Packet arm write strobe |
| cpu_arm_cnt | input | 7 | Packet byte count, 0 to 64 |
| cpu_clr_fifo | input | 1 | Firmware buffer clear pulse |
| cpu_flag_we | input | 1 | Flag clear write strobe |
| cpu_flag_bits | input | 2 | Write-1-to-clear mask: bit 0 is tx_done, bit 1 is setup_pend |
| tx_done | output | 1 | Packet acknowledged by host |
| setup_pend | output | 1 | SETUP received and not yet cleared |
| setup_rx | input | 1 | SETUP packet received pulse |
| eng_ready | output | 1 | Packet available to send (NAK when 0) |
| eng_len | output | 7 | Armed packet length |
| eng_byte | output | 8 | Byte at the current read position |
| eng_rd | input | 1 | Pop the current byte |
| eng_ack | input | 1 | Host returned ACK |
| eng_retry | input | 1 | Host did not ACK, so rewind |

## Verification
A wrong internal state shows up quickly at the ports. A lost or corrupted write pointer makes `eng_byte` show a wrong or shifted value on the first pop after arming. A read pointer that fails to rewind shows a mismatch on the first byte after a retry, in the cycle after the retry. An arm state that survives a clear, a SETUP or an ACK leaves `eng_ready` high one cycle after the event, where it must be low. A flag with the wrong precedence is visible in `tx_done` or `setup_pend` one cycle after the colliding set and clear.

// File: rtl/ctl_in_txbuf_pkg.sv
package ctl_in_txbuf_pkg;

    localparam int unsigned BUF_BYTES = 64;
    localparam int unsigned LANES     = 4;
    localparam int unsigned WORD_W    = LANES * 8;

    typedef logic [LANES-1:0] be_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    // number of enabled lanes strictly below 'lane'
    function automatic int unsigned ones_below(be_t be, int unsigned lane);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < LANES; i++) begin
            if (i < lane && be[i]) n++;
        end
        return n;
    endfunction

    function automatic int unsigned ones_all(be_t be);
        return ones_below(be, LANES);
    endfunction

endpackage

// File: rtl/ctl_in_txbuf_store.sv
module ctl_in_txbuf_store
    import ctl_in_txbuf_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_BYTES,
    parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  be_t               wr_be,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned AW    = PTR_W + 1;
    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] level;
    logic [AW-1:0]    lane_addr [LANES];
    logic [AW-1:0]    level_sum;

    always_comb begin
        for (int unsigned l = 0; l < LANES; l++) begin
            lane_addr[l] = {1'b0, level} + AW'(ones_below(wr_be, l));
        end
        level_sum = {1'b0, level} + AW'(ones_all(wr_be));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            level <= '0;
        end else if (wr_en) begin
            level <= (level_sum > DEPTH_A) ? PTR_W'(DEPTH) : level_sum[PTR_W-1:0];
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst && !flush && wr_en && wr_be[g] && lane_addr[g] < DEPTH_A) begin
                    mem[lane_addr[g][IDX_W-1:0]] <= wr_data[8*g +: 8];
                end
            end
        end
    endgenerate

    assign rd_byte = (rd_addr < PTR_W'(DEPTH)) ? mem[rd_addr[IDX_W-1:0]] : 8'h00;

endmodule

// File: rtl/ctl_in_txbuf_seq.sv
module ctl_in_txbuf_seq
    import ctl_in_txbuf_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_BYTES,
    parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lock,
    input  logic             arm_we,
    input  logic [PTR_W-1:0] arm_cnt,
    input  logic             eng_rd,
    input  logic             eng_ack,
    input  logic             eng_retry,
    output logic             armed,
    output logic             ready,
    output logic             done_evt,
    output logic [PTR_W-1:0] len,
    output logic [PTR_W-1:0] rd_ptr
);
    seq_state_e state;

    assign armed    = (state == SEQ_ARMED);
    assign ready    = armed && !lock;
    assign done_evt = ready && eng_ack && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state  <= SEQ_IDLE;
            rd_ptr <= '0;
            if (rst) len <= '0;
        end else if (state == SEQ_ARMED) begin
            if (ready && eng_ack) begin
                state  <= SEQ_IDLE;
                rd_ptr <= '0;
            end else if (ready && eng_retry) begin
                rd_ptr <= '0;
            end else if (ready && eng_rd && rd_ptr < len) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end else if (arm_we && arm_cnt <= PTR_W'(DEPTH)) begin
            state  <= SEQ_ARMED;
            len    <= arm_cnt;
            rd_ptr <= '0;
        end
    end

endmodule

// File: rtl/ctl_in_txbuf_flags.sv
module ctl_in_txbuf_flags #(
    parameter int unsigned NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_evt,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_mask,
    output logic [NFLAG-1:0] flags
);
    generate
        for (genvar f = 0; f < NFLAG; f++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    flags[f] <= 1'b0;
                end else if (set_evt[f]) begin
                    flags[f] <= 1'b1;
                end else if (clr_we && clr_mask[f]) begin
                    flags[f] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ctl_in_txbuf.sv
module ctl_in_txbuf
    import ctl_in_txbuf_pkg::*;
#(
    parameter int unsigned DEPTH = BUF_BYTES,
    parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_we,
    input  logic [WORD_W-1:0] cpu_wr_data,
    input  logic [LANES-1:0]  cpu_wr_be,
    input  logic              cpu_arm_we,
    input  logic [PTR_W-1:0]  cpu_arm_cnt,
    input  logic              cpu_clr_fifo,
    input  logic              cpu_flag_we,
    input  logic [1:0]        cpu_flag_bits,
    output logic              tx_done,
    output logic              setup_pend,
    input  logic              setup_rx,
    output logic              eng_ready,
    output logic [PTR_W-1:0]  eng_len,
    output logic [7:0]        eng_byte,
    input  logic              eng_rd,
    input  logic              eng_ack,
    input  logic              eng_retry
);
    logic             flush;
    logic             armed;
    logic             done_evt;
    logic [PTR_W-1:0] rd_ptr;
    logic [1:0]       flag_q;

    assign flush = cpu_clr_fifo || setup_rx;

    ctl_in_txbuf_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush || done_evt),
        .wr_en   (cpu_wr_we && !armed),
        .wr_data (cpu_wr_data),
        .wr_be   (cpu_wr_be),
        .rd_addr (rd_ptr),
        .rd_byte (eng_byte)
    );

    ctl_in_txbuf_seq #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lock      (setup_pend),
        .arm_we    (cpu_arm_we),
        .arm_cnt   (cpu_arm_cnt),
        .eng_rd    (eng_rd),
        .eng_ack   (eng_ack),
        .eng_retry (eng_retry),
        .armed     (armed),
        .ready     (eng_ready),
        .done_evt  (done_evt),
        .len       (eng_len),
        .rd_ptr    (rd_ptr)
    );

    ctl_in_txbuf_flags #(.NFLAG(2)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_evt  ({setup_rx, done_evt}),
        .clr_we   (cpu_flag_we),
        .clr_mask (cpu_flag_bits),
        .flags    (flag_q)
    );

    assign tx_done    = flag_q[0];
    assign setup_pend = flag_q[1];

endmodule

// File: rtl/ctl_in_txbuf_chk.sv
module ctl_in_txbuf_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PTR_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             setup_rx,
    input logic             cpu_clr_fifo,
    input logic             cpu_flag_we,
    input logic [1:0]       cpu_flag_bits,
    input logic             eng_ready,
    input logic [PTR_W-1:0] eng_len,
    input logic             eng_ack,
    input logic             eng_retry,
    input logic             tx_done,
    input logic             setup_pend
);
    a_r8_lockout: assert property (@(posedge clk) disable iff (rst)
        setup_pend |-> !eng_ready);

    a_r8_setup_sets: assert property (@(posedge clk) disable iff (rst)
        setup_rx |=> setup_pend && !eng_ready);

    a_r7_clear_disarms: assert property (@(posedge clk) disable iff (rst)
        cpu_clr_fifo |=> !eng_ready);

    a_r5_ack_done: assert property (@(posedge clk) disable iff (rst)
        (eng_ready && eng_ack && !cpu_clr_fifo && !setup_rx) |=> tx_done && !eng_ready);

    a_r6_retry_keeps: assert property (@(posedge clk) disable iff (rst)
        (eng_ready && eng_retry && !eng_ack && !cpu_clr_fifo && !setup_rx)
        |=> eng_ready && $stable(eng_len));

    a_r4_len_held: assert property (@(posedge clk) disable iff (rst)
        (eng_ready && !eng_ack && !cpu_clr_fifo && !setup_rx) |=> $stable(eng_len));

    a_r3_len_range: assert property (@(posedge clk) disable iff (rst)
        eng_ready |-> eng_len <= PTR_W'(DEPTH));

    a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
        (tx_done && cpu_flag_we && cpu_flag_bits[0] && !(eng_ready && eng_ack)) |=> !tx_done);
endmodule

bind ctl_in_txbuf ctl_in_txbuf_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .setup_rx      (setup_rx),
    .cpu_clr_fifo  (cpu_clr_fifo),
    .cpu_flag_we   (cpu_flag_we),
    .cpu_flag_bits (cpu_flag_bits),
    .eng_ready     (eng_ready),
    .eng_len       (eng_len),
    .eng_ack       (eng_ack),
    .eng_retry     (eng_retry),
    .tx_done       (tx_done),
    .setup_pend    (setup_pend)
);

// File: tb/tb_ctl_in_txbuf.sv
module tb_ctl_in_txbuf;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_wr_we = 0;
    logic [31:0] cpu_wr_data = 0;
    logic [3:0]  cpu_wr_be = 0;
    logic        cpu_arm_we = 0;
    logic [6:0]  cpu_arm_cnt = 0;
    logic        cpu_clr_fifo = 0;
    logic        cpu_flag_we = 0;
    logic [1:0]  cpu_flag_bits = 0;
    logic        tx_done, setup_pend, eng_ready;
    logic        setup_rx = 0;
    logic [6:0]  eng_len;
    logic [7:0]  eng_byte;
    logic        eng_rd = 0, eng_ack = 0, eng_retry = 0;

    int nchk = 0;
    int nerr = 0;
    bit done_flag = 0;

    // bench model
    logic [7:0] m_mem [64];
    int m_lvl = 0;
    bit m_armed = 0;
    int m_len = 0;
    bit m_setup = 0;

    always #10 clk = ~clk;

    ctl_in_txbuf dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic logic [3:0] trim_be(logic [3:0] be, int rem);
        logic [3:0] r;
        int k;
        r = 0;
        k = 0;
        for (int l = 0; l < 4; l++) begin
            if (be[l] && k < rem) begin
                r[l] = 1'b1;
                k++;
            end
        end
        return r;
    endfunction

    task automatic write_word(input logic [31:0] d, input logic [3:0] be);
        cpu_wr_we = 1; cpu_wr_data = d; cpu_wr_be = be;
        cyc();
        cpu_wr_we = 0; cpu_wr_be = 0;
        if (!m_armed) begin
            for (int l = 0; l < 4; l++) begin
                if (be[l] && m_lvl < 64) begin
                    m_mem[m_lvl] = d[8*l +: 8];
                    m_lvl++;
                end
            end
        end
    endtask

    task automatic fill(input int n);
        while (m_lvl < n) begin
            logic [3:0] be;
            be = trim_be(4'($urandom_range(1, 15)), n - m_lvl);
            if (be != 0) write_word($urandom, be);
        end
    endtask

    task automatic arm(input int n);
        cpu_arm_we = 1; cpu_arm_cnt = 7'(n);
        cyc();
        cpu_arm_we = 0;
        if (!m_armed && n <= 64) begin
            m_armed = 1;
            m_len = n;
        end
    endtask

    task automatic read_bytes(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(eng_byte), int'(m_mem[i]));
            eng_rd = 1;
            cyc();
            eng_rd = 0;
        end
    endtask

    task automatic pulse_ack();
        eng_ack = 1;
        cyc();
        eng_ack = 0;
        if (m_armed && !m_setup) begin
            m_armed = 0;
            m_lvl = 0;
        end
    endtask

    task automatic pulse_retry();
        eng_retry = 1;
        cyc();
        eng_retry = 0;
    endtask

    task automatic clr_fifo();
        cpu_clr_fifo = 1;
        cyc();
        cpu_clr_fifo = 0;
        m_armed = 0;
        m_lvl = 0;
    endtask

    task automatic w1c(input logic [1:0] m);
        cpu_flag_we = 1; cpu_flag_bits = m;
        cyc();
        cpu_flag_we = 0; cpu_flag_bits = 0;
        if (m[1]) m_setup = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1;
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 ready", eng_ready, 0);
        chk("R1 tx_done", tx_done, 0);
        chk("R1 setup_pend", setup_pend, 0);

        // R11: reads/acks while unarmed have no effect
        eng_rd = 1; cyc(); cyc(); eng_rd = 0;
        pulse_ack();
        chk("R11 no done", tx_done, 0);
        write_word(32'hA4A3A2A1, 4'b1111);
        chk("R2 not offered before arm", eng_ready, 0);
        eng_rd = 1; cyc(); eng_rd = 0;
        arm(4);
        chk("R2 ready", eng_ready, 1);
        chk("R2 len", eng_len, 4);
        read_bytes("R11 first byte intact", 4);
        pulse_ack();
        chk("R5 done", tx_done, 1);
        chk("R5 disarm", eng_ready, 0);
        w1c(2'b01);
        chk("R9 w1c", tx_done, 0);

        // R2 sparse byte enables packed in lane order
        write_word(32'h44332211, 4'b1010);
        write_word(32'h88776655, 4'b0101);
        arm(4);
        chk("R2 len sparse", eng_len, 4);
        chk("R2 byte0", eng_byte, 8'h22);
        read_bytes("R2 sparse", 4);
        pulse_ack();
        w1c(2'b01);

        // R3 count above 64 ignored, zero length arms
        arm(65);
        chk("R3 65 ignored", eng_ready, 0);
        arm(0);
        chk("R3 zero ready", eng_ready, 1);
        chk("R3 zero len", eng_len, 0);
        pulse_ack();
        chk("R3 zero done", tx_done, 1);
        w1c(2'b01);

        // R4 writes and arm while armed ignored
        fill(2);
        arm(2);
        write_word(32'hDEADBEEF, 4'b1111);
        arm(5);
        chk("R4 len held", eng_len, 2);
        read_bytes("R4 contents", 2);
        pulse_ack();
        w1c(2'b01);
        write_word(32'h0000005A, 4'b0001);
        arm(1);
        chk("R4 new pkt byte0", eng_byte, 8'h5A);
        pulse_ack();
        w1c(2'b01);

        // R10 overflow
        for (int i = 0; i < 17; i++) write_word($urandom, 4'b1111);
        chk("R10 model level", m_lvl, 64);
        arm(64);
        chk("R10 len", eng_len, 64);
        read_bytes("R10 bytes", 64);
        pulse_ack();
        w1c(2'b01);

        // R7 firmware clear
        fill(3);
        arm(3);
        clr_fifo();
        chk("R7 disarmed", eng_ready, 0);
        write_word(32'h00C3C2C1, 4'b0111);
        arm(3);
        read_bytes("R7 fresh data", 3);
        pulse_ack();
        w1c(2'b01);

        // R8 SETUP clear and lockout
        fill(4);
        arm(4);
        setup_rx = 1; cyc(); setup_rx = 0;
        m_armed = 0; m_lvl = 0; m_setup = 1;
        chk("R8 setup flag", setup_pend, 1);
        chk("R8 not ready", eng_ready, 0);
        fill(3);
        arm(3);
        chk("R8 locked", eng_ready, 0);
        pulse_ack();
        chk("R8 ack ignored", tx_done, 0);
        w1c(2'b10);
        chk("R8 flag cleared", setup_pend, 0);
        chk("R8 unlocked", eng_ready, 1);
        read_bytes("R8 bytes", 3);
        pulse_ack();

        // R9 set wins over clear
        w1c(2'b01);
        fill(1);
        arm(1);
        eng_ack = 1; cpu_flag_we = 1; cpu_flag_bits = 2'b01;
        cyc();
        eng_ack = 0; cpu_flag_we = 0; cpu_flag_bits = 0;
        m_armed = 0; m_lvl = 0;
        chk("R9 set wins done", tx_done, 1);
        setup_rx = 1; cpu_flag_we = 1; cpu_flag_bits = 2'b10;
        cyc();
        setup_rx = 0; cpu_flag_we = 0; cpu_flag_bits = 0;
        chk("R9 set wins setup", setup_pend, 1);
        w1c(2'b11);
        chk("R9 both cleared", int'({setup_pend, tx_done}), 0);

        // random packets with retries (R2, R5, R6)
        for (int p = 0; p < 40; p++) begin
            int n;
            n = $urandom_range(0, 64);
            fill(n);
            arm(n);
            chk("R2 rnd ready", eng_ready, 1);
            chk("R2 rnd len", eng_len, n);
            if ($urandom_range(0, 1) == 1) begin
                read_bytes("R2 rnd partial", $urandom_range(0, n));
                pulse_retry();
                chk("R6 still armed", eng_ready, 1);
                chk("R6 no done", tx_done, 0);
                chk("R6 len kept", eng_len, n);
            end
            read_bytes("R6 rnd full", n);
            pulse_ack();
            chk("R5 rnd done", tx_done, 1);
            chk("R5 rnd idle", eng_ready, 0);
            w1c(2'b01);
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule